// File: doc/BRIEF.md
# Execute-Stage Branch Resolver and Program Counter Steering

This block resolves control flow in the execute stage of a five-stage, in-order, 32-bit integer pipeline. It compares two source register values using a three-bit comparison kind. The kind codes are the standard conditional-branch `funct3` values. The block combines that outcome with the decoded jump and branch flags to form a redirect select.

The redirect select steers the program counter register that feeds instruction fetch. On a redirect, the register loads the target computed by the shared ALU. Otherwise it advances by one 4-byte instruction word. The ALU forms the target from the address of the branch or jump instruction itself, plus its offset; this block never forms a target itself.

The redirect select and the next address are combinational outputs, valid in the same cycle as the inputs. The program counter register updates on each rising clock edge while the advance enable is high. Hazard detection, operand forwarding, squashing of wrong-path instructions and prediction are handled elsewhere.

Top module: `bru_next_pc`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` becomes 0x00000000 on that edge, whatever the other inputs are.
- R2: At a rising edge with `adv_en` high and `pc_sel` low, `pc_q` becomes its previous value plus 4.
- R3: At a rising edge with `adv_en` high and `pc_sel` high, `pc_q` becomes the value of `alu_target` in that cycle.
- R4: At a rising edge with `adv_en` low and `rst` low, `pc_q` keeps its value, even when `pc_sel` is high.
- R5: `pc_sel` is high exactly when `do_jump` is high, or when `do_branch` and `branch_taken` are both high.
- R6: With `do_jump` high, `pc_sel` is high whatever the comparison outcome is.
- R7: With `do_jump` and `do_branch` both low, `pc_sel` is low even when `branch_taken` is high.
- R8: Kind 3'b100 (signed less-than) sets `branch_taken` when `rs1_val` is less than `rs2_val` as two's-complement numbers. Two zero operands give not-taken.
- R9: Kind 3'b110 (unsigned less-than) sets `branch_taken` when `rs1_val` is less than `rs2_val` as unsigned numbers.
- R10: Kind 3'b000 sets `branch_taken` when the operands are equal. Kind 3'b001 sets it when they differ.
- R11: Kind 3'b101 sets `branch_taken` when `rs1_val` is signed greater-or-equal to `rs2_val`. Kind 3'b111 does the same with an unsigned comparison.
- R12: Kinds 3'b010 and 3'b011 are unused and always give `branch_taken` low.
- R13: `pc_next` equals `alu_target` when `pc_sel` is high and `pc_q + 4` otherwise, in the same cycle.
- R14: The increment wraps modulo 2^32, so 0xFFFFFFFC advances to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance enable for the program counter (low while the pipeline is stalled) |
| cmp_kind | input | 3 | Comparison kind, using the conditional-branch `funct3` code |
| rs1_val | input | 32 | First source operand |
| rs2_val | input | 32 | Second source operand |
| do_jump | input | 1 | Decoded unconditional-jump flag |
| do_branch | input | 1 | Decoded conditional-branch flag |
| alu_target | input | 32 | Redirect address computed by the ALU |
| branch_taken | output | 1 | Comparison outcome |
| pc_sel | output | 1 | Redirect select for the fetch address multiplexer |
| pc_next | output | 32 | Address the program counter loads at the next enabled edge |
| pc_q | output | 32 | Current fetch program counter |

## Verification
The only internal state is the program counter register. A wrong value there shows up on `pc_q` right after the edge that wrote it. The same wrong value also shows up on `pc_next` in that cycle, because the increment path is built from it.

A comparator fault appears on `branch_taken` combinationally. With `do_branch` high, it reaches `pc_q` one enabled edge later. The operand pairs are chosen so that the signed and unsigned orderings disagree, so a swapped signedness or an inverted kind bit changes the outcome in the same cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

    // Bytes per instruction word: the sequential program counter step.
    localparam int unsigned INSN_BYTES = 4;

    // Comparison kinds keep the conditional-branch funct3 encoding.
    // Bit 2 picks ordering versus equality, bit 1 picks unsigned ordering,
    // and bit 0 inverts the outcome.
    typedef enum logic [2:0] {
        CMP_EQ   = 3'b000,
        CMP_NE   = 3'b001,
        CMP_RSV2 = 3'b010,
        CMP_RSV3 = 3'b011,
        CMP_LT   = 3'b100,
        CMP_GE   = 3'b101,
        CMP_LTU  = 3'b110,
        CMP_GEU  = 3'b111
    } cmp_kind_e;

    // Raw relations between the two operands.
    typedef struct packed {
        logic same;
        logic below;
    } cmp_rel_t;

    // Decoded control flags from the decode stage.
    typedef struct packed {
        logic jump;
        logic branch;
    } flow_ctl_t;

    // Ordering is unsigned only for the two unsigned kinds.
    function automatic logic kind_is_unsigned(cmp_kind_e k);
        return k[2] & k[1];
    endfunction

    // Map the raw relations and the kind to a taken outcome.
    function automatic logic resolve_taken(cmp_kind_e k, cmp_rel_t r);
        logic res;
        if (k[2]) begin
            res = r.below ^ k[0];
        end else if (k[1]) begin
            res = 1'b0;
        end else begin
            res = r.same ^ k[0];
        end
        return res;
    endfunction

endpackage

// File: rtl/bru_compare.sv
module bru_compare
    import bru_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter bit          SHARED_SUB = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  cmp_kind_e       kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            taken
);

    localparam int unsigned EXTW = XLEN + 2;

    cmp_rel_t rel;
    logic     uns;

    assign uns      = kind_is_unsigned(kind);
    assign rel.same = (op_a == op_b);

    generate
        if (SHARED_SUB) begin : g_shared
            // A single subtractor serves both orderings: the operands are
            // extended by two bits (sign or zero) and the top bit of the
            // difference gives the less-than result.
            logic [EXTW-1:0] a_ext, b_ext, diff;
            assign a_ext = {{2{op_a[XLEN-1] & ~uns}}, op_a};
            assign b_ext = {{2{op_b[XLEN-1] & ~uns}}, op_b};
            assign diff  = a_ext - b_ext;
            assign rel.below = diff[EXTW-1];
        end else begin : g_split
            // Two dedicated magnitude comparators, one per signedness.
            logic lt_s, lt_u;
            assign lt_s = $signed(op_a) < $signed(op_b);
            assign lt_u = op_a < op_b;
            assign rel.below = uns ? lt_u : lt_s;
        end
    endgenerate

    assign taken = resolve_taken(kind, rel);

    // R12: the unused kinds never report a taken outcome.
    a_r12_reserved: assert property (@(posedge clk) disable iff (rst)
        (kind == CMP_RSV2 || kind == CMP_RSV3) |-> !taken);

    // R10: an equality test on identical operands is always taken.
    a_r10_eq: assert property (@(posedge clk) disable iff (rst)
        (kind == CMP_EQ && op_a == op_b) |-> taken);

    // R8: zero against zero is never less-than.
    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        (kind == CMP_LT && op_a == '0 && op_b == '0) |-> !taken);

endmodule

// File: rtl/bru_select.sv
module bru_select
    import bru_pkg::*;
(
    input  flow_ctl_t ctl,
    input  logic      taken,
    output logic      redirect
);

    logic cond_hit;

    // One AND for the conditional path, one OR with the unconditional path.
    assign cond_hit = ctl.branch & taken;
    assign redirect = ctl.jump | cond_hit;

endmodule

// File: rtl/bru_pc_reg.sv
module bru_pc_reg
    import bru_pkg::*;
#(
    parameter int unsigned     XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_en,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] seq_pc;

    assign seq_pc  = pc_q + STEP;
    assign pc_next = redirect ? target : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else if (adv_en) begin
            pc_q <= pc_next;
        end
    end

    // R1: reset forces the start address.
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (pc_q == RESET_PC));

    // R4: a stalled edge leaves the counter alone.
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(pc_q));

    // R2: a sequential edge adds one instruction word.
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !redirect) |=> (pc_q == $past(pc_q) + STEP));

    // R3: a redirecting edge loads the ALU target.
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (adv_en && redirect) |=> (pc_q == $past(target)));

endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc
    import bru_pkg::*;
#(
    parameter int unsigned     XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_PC   = '0,
    parameter bit              SHARED_SUB = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_en,
    input  logic [2:0]      cmp_kind,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic            do_jump,
    input  logic            do_branch,
    input  logic [XLEN-1:0] alu_target,
    output logic            branch_taken,
    output logic            pc_sel,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);

    cmp_kind_e kind;
    flow_ctl_t ctl;

    assign kind       = cmp_kind_e'(cmp_kind);
    assign ctl.jump   = do_jump;
    assign ctl.branch = do_branch;

    bru_compare #(
        .XLEN       (XLEN),
        .SHARED_SUB (SHARED_SUB)
    ) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .op_a  (rs1_val),
        .op_b  (rs2_val),
        .taken (branch_taken)
    );

    bru_select u_sel (
        .ctl      (ctl),
        .taken    (branch_taken),
        .redirect (pc_sel)
    );

    bru_pc_reg #(
        .XLEN     (XLEN),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .adv_en   (adv_en),
        .redirect (pc_sel),
        .target   (alu_target),
        .pc_next  (pc_next),
        .pc_q     (pc_q)
    );

    // R6: an unconditional jump always redirects.
    a_r6_jump: assert property (@(posedge clk) disable iff (rst)
        do_jump |-> pc_sel);

    // R7: with neither control flag set, the comparator cannot redirect.
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (!do_jump && !do_branch) |-> !pc_sel);

    // R5: a taken conditional branch redirects.
    a_r5_branch: assert property (@(posedge clk) disable iff (rst)
        (do_branch && branch_taken) |-> pc_sel);

endmodule

// File: tb/bru_next_pc_tb.sv
module bru_next_pc_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        adv_en;
    logic [2:0]  cmp_kind;
    logic [31:0] rs1_val, rs2_val, alu_target;
    logic        do_jump, do_branch;
    logic        branch_taken, pc_sel;
    logic [31:0] pc_next, pc_q;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_next_pc dut_i (
        .clk          (clk),
        .rst          (rst),
        .adv_en       (adv_en),
        .cmp_kind     (cmp_kind),
        .rs1_val      (rs1_val),
        .rs2_val      (rs2_val),
        .do_jump      (do_jump),
        .do_branch    (do_branch),
        .alu_target   (alu_target),
        .branch_taken (branch_taken),
        .pc_sel       (pc_sel),
        .pc_next      (pc_next),
        .pc_q         (pc_q)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs change after the falling edge; results are sampled 1 time unit later.
    task automatic set_ops(logic [2:0] k, logic [31:0] a, logic [31:0] b);
        cmp_kind = k;
        rs1_val  = a;
        rs2_val  = b;
        #1;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; adv_en = 1'b1; do_jump = 1'b0; do_branch = 1'b0;
        cmp_kind = 3'b000; rs1_val = '0; rs2_val = '0; alu_target = 32'h0000_0F00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc after reset", pc_q, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_step;
        adv_en = 1'b1; do_jump = 1'b0; do_branch = 1'b0;
        for (int i = 1; i <= 3; i++) begin
            tick();
            check("R2 sequential advance", pc_q, 32'(i * 4));
        end
    endtask

    task automatic t_hold;
        adv_en = 1'b0;
        repeat (2) tick();
        check("R4 hold while stalled", pc_q, 32'd12);
        do_jump = 1'b1; alu_target = 32'h0000_0800;
        #1;
        check("R4 stall with redirect pending, pc_sel", {31'b0, pc_sel}, 32'd1);
        tick();
        check("R4 hold ignores redirect", pc_q, 32'd12);
        do_jump = 1'b0;
        adv_en = 1'b1;
    endtask

    task automatic t_lt_zero;
        do_branch = 1'b1; alu_target = 32'h0000_0200;
        set_ops(3'b100, 32'h0, 32'h0);
        check("R8 zero lt zero taken", {31'b0, branch_taken}, 32'd0);
        check("R5 not-taken branch pc_sel", {31'b0, pc_sel}, 32'd0);
        check("R13 next is pc+4", pc_next, 32'd16);
        tick();
        check("R2 not-taken advance", pc_q, 32'd16);
    endtask

    task automatic t_lt_signed;
        do_branch = 1'b1; alu_target = 32'h0000_0100;
        set_ops(3'b100, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R8 signed -1 lt 1", {31'b0, branch_taken}, 32'd1);
        check("R5 taken branch pc_sel", {31'b0, pc_sel}, 32'd1);
        check("R13 next is target", pc_next, 32'h0000_0100);
        tick();
        check("R3 load target", pc_q, 32'h0000_0100);
        set_ops(3'b100, 32'h0000_0001, 32'hFFFF_FFFF);
        check("R8 signed 1 lt -1", {31'b0, branch_taken}, 32'd0);
    endtask

    task automatic t_ltu;
        adv_en = 1'b0;
        set_ops(3'b110, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R9 unsigned max lt 1", {31'b0, branch_taken}, 32'd0);
        set_ops(3'b110, 32'h0000_0001, 32'hFFFF_FFFF);
        check("R9 unsigned 1 lt max", {31'b0, branch_taken}, 32'd1);
        set_ops(3'b110, 32'h7FFF_FFFF, 32'h8000_0000);
        check("R9 unsigned across sign bit", {31'b0, branch_taken}, 32'd1);
    endtask

    task automatic t_eq_ne;
        set_ops(3'b000, 32'h5, 32'h5);
        check("R10 eq equal", {31'b0, branch_taken}, 32'd1);
        set_ops(3'b001, 32'h5, 32'h5);
        check("R10 ne equal", {31'b0, branch_taken}, 32'd0);
        set_ops(3'b001, 32'h5, 32'h8000_0005);
        check("R10 ne differ", {31'b0, branch_taken}, 32'd1);
        set_ops(3'b000, 32'h5, 32'h8000_0005);
        check("R10 eq differ", {31'b0, branch_taken}, 32'd0);
    endtask

    task automatic t_ge;
        set_ops(3'b101, 32'hFFFF_FFFF, 32'h1);
        check("R11 signed -1 ge 1", {31'b0, branch_taken}, 32'd0);
        set_ops(3'b101, 32'h7, 32'h7);
        check("R11 signed ge equal", {31'b0, branch_taken}, 32'd1);
        set_ops(3'b111, 32'hFFFF_FFFF, 32'h1);
        check("R11 unsigned max ge 1", {31'b0, branch_taken}, 32'd1);
        set_ops(3'b111, 32'h1, 32'h2);
        check("R11 unsigned 1 ge 2", {31'b0, branch_taken}, 32'd0);
    endtask

    task automatic t_reserved;
        set_ops(3'b010, 32'h5, 32'h5);
        check("R12 kind 010", {31'b0, branch_taken}, 32'd0);
        set_ops(3'b011, 32'h1, 32'h5);
        check("R12 kind 011", {31'b0, branch_taken}, 32'd0);
        check("R12 no redirect from unused kind", {31'b0, pc_sel}, 32'd0);
        adv_en = 1'b1;
    endtask

    task automatic t_jump;
        do_branch = 1'b0; do_jump = 1'b1; alu_target = 32'h0000_0040;
        set_ops(3'b100, 32'h0, 32'h0);
        check("R6 jump with false compare", {31'b0, pc_sel}, 32'd1);
        tick();
        check("R3 jump loads target", pc_q, 32'h0000_0040);
    endtask

    task automatic t_idle;
        do_jump = 1'b0; do_branch = 1'b0; alu_target = 32'h0000_0900;
        set_ops(3'b000, 32'h3, 32'h3);
        check("R7 compare true", {31'b0, branch_taken}, 32'd1);
        check("R7 idle pc_sel", {31'b0, pc_sel}, 32'd0);
        check("R13 idle next", pc_next, 32'h0000_0044);
        tick();
        check("R7 idle advance", pc_q, 32'h0000_0044);
    endtask

    task automatic t_wrap;
        do_jump = 1'b1; alu_target = 32'hFFFF_FFFC;
        #1;
        tick();
        check("R3 load top address", pc_q, 32'hFFFF_FFFC);
        do_jump = 1'b0;
        #1;
        check("R14 next wraps", pc_next, 32'h0);
        tick();
        check("R14 wrap to zero", pc_q, 32'h0);
    endtask

    task automatic t_mid_reset;
        tick();
        check("R2 advance before reset", pc_q, 32'h4);
        rst = 1'b1; do_jump = 1'b1; alu_target = 32'h0000_0777;
        tick();
        check("R1 reset overrides jump", pc_q, 32'h0);
        rst = 1'b0; do_jump = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    endtask

    initial begin
        t_reset();
        t_step();
        t_hold();
        t_lt_zero();
        t_lt_signed();
        t_ltu();
        t_eq_ne();
        t_ge();
        t_reserved();
        t_jump();
        t_idle();
        t_wrap();
        t_mid_reset();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule